// File: doc/BRIEF.md
# Lockable Byte Register Map with Two-Write Command Keys

This block is the register map behind a byte-oriented serial bus slave for an elapsed-time and event recorder. It presents 32 byte locations through a single pointer that the bus logic loads with the register address. After that, each byte written or read moves the pointer on by one. The map holds a configuration byte, a four-byte alarm threshold and ten bytes of general-purpose user storage. It also shows the 32-bit time count and the 17-bit event count, which are owned by a separate counter block. Writes to those count bytes go out as byte-write strobes to that block. A clear request goes out on its own strobe.

The three highest addresses are command keys. A protective action takes place only when the same key byte is written twice to its own key address. Writes to other addresses may fall between the two. Any other value written to the key address, or a power-on reset, cancels a half-entered command. The first key clears the counters, clears the alarm flag, and freezes the configuration byte for good. The second key write-protects the alarm and count bytes. The third key write-protects the user bytes. A write that lands on a protected or read-only location is dropped without any error, and the pointer still advances.

Top module: `lockable_regfile`

## Requirements
- R1: After rst_n is low, every stored bit is zero (alarm bytes, user bytes, configuration bits, lock flags and armed keys), and the pointer is 00h.
- R2: Asserting bus_ptr_load loads the pointer with bus_ptr_val, and any read or write strobe in that cycle is ignored. Otherwise each bus_wr or bus_rd strobe advances the pointer by one, and 1Fh wraps to 00h. bus_rdata always shows the byte at the pointer.
- R3: Address 00h reads {0, AF, WDF, WMDF, AOS, RE, AP, event_cnt_i[16]}, with bit 7 first. Only bits 3 (AOS), 2 (RE) and 1 (AP) take written values. AOS, AP and AF drive out_sel_o, out_pol_o and alarm_flag_o.
- R4: Addresses 01h–04h hold the alarm threshold, low byte first, and it is presented on alarm_val_o. Addresses 05h–08h read time_cnt_i and 09h–0Ah read event_cnt_i[15:0], each low byte first.
- R5: While the count lock is clear, a write to 05h–0Ah pulses cnt_wr_o in that same cycle. cnt_wr_sel_o is set to the address minus 05h and cnt_wr_data_o to the written byte.
- R6: Addresses 0Bh–14h are ten read/write user bytes.
- R7: Addresses 15h–1Fh always read 00h. Writes to 15h–1Ch change nothing.
- R8: alarm_hit_i sets AF. AF stays set until a counter-clear command, which wins if both happen in the same cycle.
- R9: Each key address has its own armed bit. Writing its key byte when it is not armed arms it. Writing the key byte when it is armed fires the command and disarms. Writing any other value to that address disarms it. Writes to other addresses leave it alone.
- R10: Key 55h at 1Dh fires a counter clear only while RE=1 and the configuration is not frozen. It pulses cnt_clear_o in the second write cycle, clears AF and RE, and freezes the configuration byte, so later configuration writes and later clear commands have no effect.
- R11: Key AAh at 1Eh sets WDF for good. From then on, writes to 01h–0Ah are dropped and cnt_wr_o stays low.
- R12: Key F0h at 1Fh sets WMDF for good. From then on, writes to 0Bh–14h are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-on) |
| bus_ptr_load | input | 1 | Load pointer from bus_ptr_val |
| bus_ptr_val | input | 5 | New pointer value |
| bus_wr | input | 1 | Byte write strobe at pointer |
| bus_wdata | input | 8 | Byte to write |
| bus_rd | input | 1 | Byte read strobe (advances pointer) |
| bus_rdata | output | 8 | Byte at current pointer |
| bus_ptr_o | output | 5 | Current pointer |
| time_cnt_i | input | 32 | Time count from counter block |
| event_cnt_i | input | 17 | Event count from counter block |
| alarm_hit_i | input | 1 | Counter block reports time equals alarm |
| cnt_wr_o | output | 1 | Byte write strobe to counter block |
| cnt_wr_sel_o | output | 3 | Count byte index (0–3 time, 4–5 event) |
| cnt_wr_data_o | output | 8 | Count byte value |
| cnt_clear_o | output | 1 | One-cycle counter clear request |
| alarm_val_o | output | 32 | Alarm threshold |
| out_sel_o | output | 1 | Alarm output style select (AOS) |
| out_pol_o | output | 1 | Alarm output polarity (AP) |
| alarm_flag_o | output | 1 | Alarm flag (AF) |
| wr_lock_o | output | 1 | Alarm/count write lock (WDF) |
| mem_lock_o | output | 1 | User byte write lock (WMDF) |

## Verification
All 256 values are written to the configuration byte and read back. This separates the three writable bits from the read-only and zero bits. The whole map is written in one pass that wraps through 1Fh, using two complementary address-derived patterns, and then read back in one pass. These passes catch errors in decode boundaries, byte order and pointer wrap, and show that the spare and key locations do not store. Key sequences are run with an unrelated write between the two key writes, with a wrong byte between them, with a reset between them, and with RE clear. These runs separate correct arming from firing on any second write, and a real clear from an ignored one. After each lock is set, the full-map sweeps are repeated to confirm that exactly the guarded regions stop changing.

// File: rtl/lrf_pkg.sv
package lrf_pkg;
  localparam int AW    = 5;
  localparam int DW    = 8;
  localparam int NKEYS = 3;

  typedef enum logic [2:0] {
    RG_CFG, RG_ALARM, RG_TIME, RG_EVENT, RG_USER, RG_SPARE, RG_KEY
  } region_e;

  // key byte per key slot: 0 = counter clear, 1 = count lock, 2 = user lock
  function automatic logic [DW-1:0] key_code(input int k);
    case (k)
      0:       return 8'h55;
      1:       return 8'hAA;
      default: return 8'hF0;
    endcase
  endfunction

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return p + AW'(1);
  endfunction
endpackage

// File: rtl/lrf_ptr.sv
module lrf_ptr
  import lrf_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  output logic [AW-1:0] ptr_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr_o <= '0;
    else if (load) ptr_o <= load_val;
    else if (step) ptr_o <= ptr_next(ptr_o);
  end

  // R2
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ptr_o == $past(load_val));
endmodule

// File: rtl/lrf_decode.sv
module lrf_decode
  import lrf_pkg::*;
#(
  parameter int ALARM_BYTES = 4,
  parameter int TIME_BYTES  = 4,
  parameter int EVT_BYTES   = 2,
  parameter int USER_BYTES  = 10
) (
  input  logic [AW-1:0] addr,
  output region_e       region,
  output logic [AW-1:0] idx
);
  localparam int ALM_BASE = 1;
  localparam int TIM_BASE = ALM_BASE + ALARM_BYTES;
  localparam int EVT_BASE = TIM_BASE + TIME_BYTES;
  localparam int USR_BASE = EVT_BASE + EVT_BYTES;
  localparam int SPR_BASE = USR_BASE + USER_BYTES;
  localparam int KEY_BASE = (1 << AW) - NKEYS;

  always_comb begin
    int a;
    a = int'(addr);
    region = RG_SPARE;
    idx    = '0;
    if (a == 0) begin
      region = RG_CFG;
    end else if (a < TIM_BASE) begin
      region = RG_ALARM; idx = AW'(a - ALM_BASE);
    end else if (a < EVT_BASE) begin
      region = RG_TIME;  idx = AW'(a - TIM_BASE);
    end else if (a < USR_BASE) begin
      region = RG_EVENT; idx = AW'(a - EVT_BASE);
    end else if (a < SPR_BASE) begin
      region = RG_USER;  idx = AW'(a - USR_BASE);
    end else if (a >= KEY_BASE) begin
      region = RG_KEY;   idx = AW'(a - KEY_BASE);
    end
  end
endmodule

// File: rtl/lrf_key.sv
module lrf_key
  import lrf_pkg::*;
#(
  parameter logic [DW-1:0] CODE = 8'h55
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  input  logic [DW-1:0] data,
  output logic          armed_o,
  output logic          fire_o
);
  logic match;
  assign match  = hit && (data == CODE);
  assign fire_o = match && armed_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   armed_o <= 1'b0;
    else if (hit) armed_o <= match && !armed_o;
  end

  // R9
  key_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> !armed_o);
  // R9
  key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> armed_o == $past(armed_o));
endmodule

// File: rtl/lockable_regfile.sv
module lockable_regfile
  import lrf_pkg::*;
#(
  parameter int ALARM_BYTES = 4,
  parameter int TIME_BYTES  = 4,
  parameter int EVT_BYTES   = 2,
  parameter int USER_BYTES  = 10,
  localparam int TIME_W = TIME_BYTES * 8,
  localparam int EVT_W  = EVT_BYTES * 8 + 1,
  localparam int ALM_W  = ALARM_BYTES * 8,
  localparam int CSEL_W = $clog2(TIME_BYTES + EVT_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_ptr_load,
  input  logic [AW-1:0]     bus_ptr_val,
  input  logic              bus_wr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              bus_rd,
  output logic [DW-1:0]     bus_rdata,
  output logic [AW-1:0]     bus_ptr_o,
  input  logic [TIME_W-1:0] time_cnt_i,
  input  logic [EVT_W-1:0]  event_cnt_i,
  input  logic              alarm_hit_i,
  output logic              cnt_wr_o,
  output logic [CSEL_W-1:0] cnt_wr_sel_o,
  output logic [DW-1:0]     cnt_wr_data_o,
  output logic              cnt_clear_o,
  output logic [ALM_W-1:0]  alarm_val_o,
  output logic              out_sel_o,
  output logic              out_pol_o,
  output logic              alarm_flag_o,
  output logic              wr_lock_o,
  output logic              mem_lock_o
);
  localparam int TSEL_W = $clog2(TIME_BYTES);

  // ---------------- pointer and decode ----------------
  logic          wr_go, rd_go;
  region_e       region;
  logic [AW-1:0] idx;

  assign wr_go = bus_wr && !bus_ptr_load;
  assign rd_go = bus_rd && !bus_ptr_load;

  lrf_ptr u_ptr (
    .clk(clk), .rst_n(rst_n), .load(bus_ptr_load), .load_val(bus_ptr_val),
    .step(wr_go || rd_go), .ptr_o(bus_ptr_o)
  );

  lrf_decode #(
    .ALARM_BYTES(ALARM_BYTES), .TIME_BYTES(TIME_BYTES),
    .EVT_BYTES(EVT_BYTES), .USER_BYTES(USER_BYTES)
  ) u_dec (
    .addr(bus_ptr_o), .region(region), .idx(idx)
  );

  // ---------------- state ----------------
  logic aos_q, re_q, ap_q, af_q, wdf_q, wmdf_q, frozen_q;
  logic [DW-1:0] alarm_q [ALARM_BYTES];
  logic [DW-1:0] user_q  [USER_BYTES];

  // ---------------- command keys ----------------
  logic [NKEYS-1:0] key_hit, key_armed, key_fire;
  for (genvar k = 0; k < NKEYS; k++) begin : g_key
    assign key_hit[k] = wr_go && (region == RG_KEY) && (idx == AW'(k));
    lrf_key #(.CODE(key_code(k))) u_key (
      .clk(clk), .rst_n(rst_n), .hit(key_hit[k]), .data(bus_wdata),
      .armed_o(key_armed[k]), .fire_o(key_fire[k])
    );
  end

  logic clr_cmd, wdf_cmd, wmdf_cmd;
  assign clr_cmd  = key_fire[0] && re_q && !frozen_q;
  assign wdf_cmd  = key_fire[1];
  assign wmdf_cmd = key_fire[2];

  // ---------------- write enables ----------------
  logic cfg_we, alarm_we, user_we, cnt_we;
  assign cfg_we   = wr_go && (region == RG_CFG)   && !frozen_q;
  assign alarm_we = wr_go && (region == RG_ALARM) && !wdf_q;
  assign user_we  = wr_go && (region == RG_USER)  && !wmdf_q;
  assign cnt_we   = wr_go && ((region == RG_TIME) || (region == RG_EVENT)) && !wdf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aos_q <= 1'b0; re_q <= 1'b0; ap_q <= 1'b0; af_q <= 1'b0;
      wdf_q <= 1'b0; wmdf_q <= 1'b0; frozen_q <= 1'b0;
    end else begin
      if (cfg_we) begin
        aos_q <= bus_wdata[3];
        re_q  <= bus_wdata[2];
        ap_q  <= bus_wdata[1];
      end
      if (clr_cmd) begin
        re_q     <= 1'b0;
        frozen_q <= 1'b1;
        af_q     <= 1'b0;
      end else if (alarm_hit_i) begin
        af_q <= 1'b1;
      end
      if (wdf_cmd)  wdf_q  <= 1'b1;
      if (wmdf_cmd) wmdf_q <= 1'b1;
    end
  end

  for (genvar g = 0; g < ALARM_BYTES; g++) begin : g_alarm
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             alarm_q[g] <= '0;
      else if (alarm_we && idx == AW'(g))     alarm_q[g] <= bus_wdata;
    end
    assign alarm_val_o[8*g +: 8] = alarm_q[g];
    // R11
    alarm_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wdf_q |=> $stable(alarm_q[g]));
  end

  for (genvar g = 0; g < USER_BYTES; g++) begin : g_user
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             user_q[g] <= '0;
      else if (user_we && idx == AW'(g))      user_q[g] <= bus_wdata;
    end
    // R12
    user_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wmdf_q |=> $stable(user_q[g]));
  end

  // ---------------- counter block side ----------------
  assign cnt_wr_o      = cnt_we;
  assign cnt_wr_data_o = bus_wdata;
  assign cnt_wr_sel_o  = (region == RG_TIME) ? CSEL_W'(idx)
                                             : CSEL_W'(TIME_BYTES + int'(idx));
  assign cnt_clear_o   = clr_cmd;

  assign out_sel_o    = aos_q;
  assign out_pol_o    = ap_q;
  assign alarm_flag_o = af_q;
  assign wr_lock_o    = wdf_q;
  assign mem_lock_o   = wmdf_q;

  // ---------------- read mux ----------------
  logic [TSEL_W-1:0] tsel;
  assign tsel = idx[TSEL_W-1:0];

  always_comb begin
    bus_rdata = '0;
    case (region)
      RG_CFG:   bus_rdata = {1'b0, af_q, wdf_q, wmdf_q, aos_q, re_q, ap_q,
                             event_cnt_i[EVT_W-1]};
      RG_ALARM: for (int i = 0; i < ALARM_BYTES; i++)
                  if (idx == AW'(i)) bus_rdata = alarm_q[i];
      RG_TIME:  bus_rdata = time_cnt_i[8*tsel +: 8];
      RG_EVENT: for (int i = 0; i < EVT_BYTES; i++)
                  if (idx == AW'(i)) bus_rdata = event_cnt_i[8*i +: 8];
      RG_USER:  for (int i = 0; i < USER_BYTES; i++)
                  if (idx == AW'(i)) bus_rdata = user_q[i];
      default:  bus_rdata = '0;
    endcase
  end

  // ---------------- assertions ----------------
  // R2
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr || bus_rd) && !bus_ptr_load |=> bus_ptr_o == AW'($past(bus_ptr_o) + 1));
  // R11
  wdf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdf_q |=> wdf_q);
  // R12
  wmdf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wmdf_q |=> wmdf_q);
  // R11
  cnt_wr_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wdf_q) |-> !cnt_wr_o);
  // R10
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frozen_q |=> frozen_q && $stable({aos_q, re_q, ap_q}) && !cnt_clear_o);
  // R10
  clear_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clear_o |=> !af_q && !re_q && frozen_q);
  // R8
  af_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    af_q && !cnt_clear_o |=> af_q);
endmodule

// File: tb/lockable_regfile_tb.sv
module lockable_regfile_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_ptr_load = 0;
  logic [4:0]  bus_ptr_val = 0;
  logic        bus_wr = 0;
  logic [7:0]  bus_wdata = 0;
  logic        bus_rd = 0;
  logic [7:0]  bus_rdata;
  logic [4:0]  bus_ptr_o;
  logic [31:0] time_cnt_i = 0;
  logic [16:0] event_cnt_i = 0;
  logic        alarm_hit_i = 0;
  logic        cnt_wr_o;
  logic [2:0]  cnt_wr_sel_o;
  logic [7:0]  cnt_wr_data_o;
  logic        cnt_clear_o;
  logic [31:0] alarm_val_o;
  logic        out_sel_o, out_pol_o, alarm_flag_o, wr_lock_o, mem_lock_o;

  always #2 clk = ~clk;

  lockable_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .bus_ptr_load(bus_ptr_load), .bus_ptr_val(bus_ptr_val),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .bus_ptr_o(bus_ptr_o), .time_cnt_i(time_cnt_i), .event_cnt_i(event_cnt_i),
    .alarm_hit_i(alarm_hit_i), .cnt_wr_o(cnt_wr_o), .cnt_wr_sel_o(cnt_wr_sel_o),
    .cnt_wr_data_o(cnt_wr_data_o), .cnt_clear_o(cnt_clear_o), .alarm_val_o(alarm_val_o),
    .out_sel_o(out_sel_o), .out_pol_o(out_pol_o), .alarm_flag_o(alarm_flag_o),
    .wr_lock_o(wr_lock_o), .mem_lock_o(mem_lock_o)
  );

  int n_chk = 0, n_bad = 0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // ---------------- reference model ----------------
  bit m_aos, m_re, m_ap, m_af, m_wdf, m_wmdf, m_frz;
  logic [7:0] m_alarm [4];
  logic [7:0] m_user  [10];
  bit [2:0]   m_arm;
  int         mptr;

  task automatic model_clear();
    m_aos = 0; m_re = 0; m_ap = 0; m_af = 0; m_wdf = 0; m_wmdf = 0; m_frz = 0;
    m_arm = 0; mptr = 0;
    for (int i = 0; i < 4; i++) m_alarm[i] = 0;
    for (int i = 0; i < 10; i++) m_user[i] = 0;
  endtask

  function automatic logic [7:0] exp_read(input int a);
    if (a == 0)  return {1'b0, m_af, m_wdf, m_wmdf, m_aos, m_re, m_ap, event_cnt_i[16]};
    if (a <= 4)  return m_alarm[a-1];
    if (a <= 8)  return 8'((time_cnt_i >> (8*(a-5))) & 32'hFF);
    if (a <= 10) return 8'((event_cnt_i >> (8*(a-9))) & 17'hFF);
    if (a <= 20) return m_user[a-11];
    return 8'h00;
  endfunction

  function automatic logic [7:0] code_of(input int k);
    return (k == 0) ? 8'h55 : (k == 1) ? 8'hAA : 8'hF0;
  endfunction

  // ---------------- bus tasks ----------------
  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    model_clear();
  endtask

  task automatic set_ptr(input int a);
    bus_ptr_load = 1; bus_ptr_val = 5'(a);
    bus_wr = 1; bus_wdata = 8'hC3;   // R2: strobe alongside load must be ignored
    @(posedge clk); #1;
    bus_ptr_load = 0; bus_wr = 0;
    mptr = a;
  endtask

  task automatic wr(input logic [7:0] d);
    bit exp_cw, exp_clr;
    int k;
    exp_cw  = (mptr >= 5 && mptr <= 10) && !m_wdf;
    exp_clr = (mptr == 29) && (d == 8'h55) && m_arm[0] && m_re && !m_frz;
    bus_wr = 1; bus_wdata = d;
    @(negedge clk);
    chk("R5 cnt_wr_o", 32'(cnt_wr_o), 32'(exp_cw));
    if (exp_cw) begin
      chk("R5 cnt_wr_sel_o", 32'(cnt_wr_sel_o), 32'(mptr - 5));
      chk("R5 cnt_wr_data_o", 32'(cnt_wr_data_o), 32'(d));
    end
    chk("R10 cnt_clear_o", 32'(cnt_clear_o), 32'(exp_clr));
    @(posedge clk); #1;
    bus_wr = 0;
    // model update
    if (mptr == 0 && !m_frz) begin m_aos = d[3]; m_re = d[2]; m_ap = d[1]; end
    if (mptr >= 1 && mptr <= 4 && !m_wdf) m_alarm[mptr-1] = d;
    if (mptr >= 11 && mptr <= 20 && !m_wmdf) m_user[mptr-11] = d;
    if (mptr >= 29) begin
      k = mptr - 29;
      if (d == code_of(k)) begin
        if (m_arm[k]) begin
          m_arm[k] = 0;
          if (k == 0 && m_re && !m_frz) begin m_re = 0; m_af = 0; m_frz = 1; end
          if (k == 1) m_wdf = 1;
          if (k == 2) m_wmdf = 1;
        end else m_arm[k] = 1;
      end else m_arm[k] = 0;
    end
    mptr = (mptr + 1) % 32;
  endtask

  task automatic rd(input string tag);
    bus_rd = 1;
    @(negedge clk);
    chk(tag, 32'(bus_rdata), 32'(exp_read(mptr)));
    @(posedge clk); #1;
    bus_rd = 0;
    mptr = (mptr + 1) % 32;
  endtask

  task automatic check_all(input string tag);
    set_ptr(0);
    for (int a = 0; a < 32; a++) rd($sformatf("R4/R6/R7 %s addr %0h", tag, a));
    @(negedge clk);
    chk({"R2 wrap ", tag}, 32'(bus_ptr_o), 32'h0);
    chk({"R4 alarm_val_o ", tag}, alarm_val_o,
        {m_alarm[3], m_alarm[2], m_alarm[1], m_alarm[0]});
    chk({"R3 flags ", tag}, 32'({out_sel_o, out_pol_o, alarm_flag_o, wr_lock_o, mem_lock_o}),
        32'({m_aos, m_ap, m_af, m_wdf, m_wmdf}));
    @(posedge clk); #1;
  endtask

  task automatic sweep(input bit inv);
    set_ptr(0);
    for (int a = 0; a < 32; a++) begin
      logic [7:0] p;
      p = 8'((a * 29 + 11) & 255);
      wr(inv ? ~p : p);
    end
  endtask

  task automatic key_at(input int a, input logic [7:0] d);
    set_ptr(a);
    wr(d);
  endtask

  task automatic hit_alarm();
    alarm_hit_i = 1;
    @(posedge clk); #1;
    alarm_hit_i = 0;
    m_af = 1;
  endtask

  // ---------------- stimulus ----------------
  initial begin
    model_clear();
    do_reset();
    // R1 reset state
    @(negedge clk);
    chk("R1 ptr after reset", 32'(bus_ptr_o), 0);
    @(posedge clk); #1;
    check_all("R1 reset");

    // R3 exhaustive configuration byte sweep
    for (int v = 0; v < 256; v++) begin
      set_ptr(0);
      wr(8'(v));
      set_ptr(0);
      rd($sformatf("R3 cfg write %02h", v));
    end
    set_ptr(0); wr(8'h00);

    // R2 R4 R5 R6 R7 full-map sweeps with live counter inputs
    time_cnt_i  = 32'h89AB_CDEF;
    event_cnt_i = 17'h1_2345;
    sweep(0);
    @(negedge clk);
    chk("R2 ptr after 32 writes", 32'(bus_ptr_o), 0);
    @(posedge clk); #1;
    check_all("pattern A");
    sweep(1);
    check_all("pattern B");
    event_cnt_i = 17'h0_5A5A;
    check_all("ECMSB low");

    // R8 alarm flag sticky
    hit_alarm();
    repeat (3) @(posedge clk); #1;
    check_all("R8 af set");

    // R9 reset between key writes cancels arming
    key_at(31, 8'hF0);
    do_reset();
    key_at(31, 8'hF0);
    check_all("R9 rst_n disarm");
    do_reset();
    event_cnt_i = 17'h1_0001;

    // R10 clear ignored while RE=0
    key_at(29, 8'h55);
    key_at(29, 8'h55);
    hit_alarm();
    check_all("R10 RE=0 ignored");
    // R10 R9 clear with an unrelated write in between
    set_ptr(0); wr(8'h04);
    key_at(29, 8'h55);
    set_ptr(11); wr(8'h33);
    key_at(29, 8'h55);
    check_all("R10 cleared");
    set_ptr(0); wr(8'hFF);
    key_at(29, 8'h55);
    key_at(29, 8'h55);
    check_all("R10 frozen");

    // R9 R11 wrong byte disarms, then lock
    key_at(30, 8'hAA);
    key_at(30, 8'h00);
    key_at(30, 8'hAA);
    check_all("R9 disarm");
    key_at(30, 8'hAA);
    check_all("R11 locked");
    sweep(0);
    check_all("R11 sweep after lock");

    // R12 user lock
    key_at(31, 8'hF0);
    key_at(31, 8'hF0);
    sweep(1);
    check_all("R12 sweep after lock");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule